// File: doc/BRIEF.md
# Selectable Conversion Trigger Unit

This block issues the one-cycle start pulse that launches a conversion in a digital-to-analog converter controller. Eight candidate sources feed it: a self-clearing software trigger bit, one external pin, four timer event lines and two PWM event lines. A 3-bit select chooses which of them may start a conversion, and a global trigger enable gates the whole unit.

The external pin is asynchronous. It passes through a two-flop synchronizer and is then qualified in one of four ways: active-low level, active-high level, falling edge or rising edge. Level qualification fires on every cycle the level is present, unless the controller reports that it is busy. Edge qualification compares the current synchronized sample with a history register. That history register is cleared while the unit is disabled. The edge path is also held off for two cycles whenever the source or mode changes, so reconfiguration cannot produce a stray start.

Two small state machines carry the sequencing.

The control machine has three states:
- `CS_OFF`: the unit is disabled.
- `CS_RUN`: normal operation.
- `CS_PRIME`: a one-cycle hold-off after a configuration change.

Its transitions are:
- `CS_OFF` to `CS_RUN` when enable rises.
- `CS_RUN` or `CS_PRIME` to `CS_OFF` when enable falls.
- `CS_RUN` or `CS_PRIME` to `CS_PRIME` when the source or mode changes.
- `CS_PRIME` to `CS_RUN` once the configuration has been stable for a cycle.

The software machine has two states, `SW_IDLE` and `SW_ARMED`. A write of 1 moves it to `SW_ARMED`. It returns to `SW_IDLE` on the next cycle unless a further write of 1 arrives.

Top module: `conv_trig_sel`

## Requirements
- R1: The source select chooses the start source with this encoding: 0 software bit, 1 external pin, 2 to 5 timer events 0 to 3, 6 PWM event 0, 7 PWM event 1. A stimulus on any unselected source produces no start.
- R2: While `trig_en` is 0, no start is issued. The edge history is cleared in that time, so enabling the unit while the pin already sits high in rising-edge mode produces no start.
- R3: A cycle with `sw_wr`=1 and `sw_wdata`=1 (source 0, enabled) gives exactly one start, visible after the second rising clock edge following that cycle. A write with `sw_wdata`=0 gives none. `sw_bit_rd` always reads 0.
- R4: A timer or PWM event pulse on the selected line appears on `start` after the next rising clock edge, as a single pulse.
- R5: In edge mode, a pin transition shows on `start` after the third rising edge following the pin change: two synchronizer flops, then the output register.
- R6: The pin mode encoding is: 0 low level, 1 high level, 2 falling edge, 3 rising edge. Level modes fire on every cycle the synchronized level is present. Edge modes fire once per transition.
- R7: `busy`=1 suppresses starts from the level modes but not from the edge modes.
- R8: A change of `src_sel` or `pin_mode` while enabled blocks edge qualification in the cycle of the change and in the cycle after it. An edge reaching the qualifier then is discarded, and no spurious start results from the change.
- R9: During and right after reset, `start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_en | input | 1 | Trigger enable; 0 blocks all starts |
| src_sel | input | 3 | Start source select |
| pin_mode | input | 2 | External pin qualification mode |
| sw_wr | input | 1 | Software trigger register write strobe |
| sw_wdata | input | 1 | Data written to the software trigger bit |
| pin_raw | input | 1 | Asynchronous external trigger pin |
| evt_tmr | input | 4 | Timer event pulses, one per timer |
| evt_pwm | input | 2 | PWM event pulses, one per PWM unit |
| busy | input | 1 | Controller busy; masks level-mode starts |
| start | output | 1 | Registered conversion start pulse |
| sw_bit_rd | output | 1 | Read value of the software trigger bit (always 0) |

## Verification
The sharpest collision is a synchronized pin edge that reaches the qualifier in the very cycle the mode register is rewritten. The bench raises the pin, waits two clock edges and switches from falling-edge to rising-edge mode on the following half cycle. The rising edge then arrives exactly in the hold-off cycle, so the bench expects no start in the following window. The second overlap is `busy` against a present level: the level window is swept with `busy` held high and low. The expected counts are derived arithmetically: pulse width for the level modes, one per transition for the edge modes, and zero for masked levels.

// File: rtl/conv_trig_pkg.sv
`timescale 1ns/1ps
package conv_trig_pkg;

    // pin qualification modes; encoding is decoded by the qualifier
    typedef enum logic [1:0] {
        PM_LOW  = 2'd0,
        PM_HIGH = 2'd1,
        PM_FALL = 2'd2,
        PM_RISE = 2'd3
    } pmode_e;

    // control sequencer states
    typedef enum logic [1:0] {
        CS_OFF   = 2'd0,
        CS_RUN   = 2'd1,
        CS_PRIME = 2'd2
    } ctl_state_e;

    // software trigger states
    typedef enum logic {
        SW_IDLE  = 1'b0,
        SW_ARMED = 1'b1
    } sw_state_e;

    localparam int SRC_SOFT_IDX = 0;
    localparam int SRC_PIN_IDX  = 1;

endpackage

// File: rtl/cts_pin_sync.sv
`timescale 1ns/1ps
module cts_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES >= 2) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cts_ctl_fsm.sv
`timescale 1ns/1ps
module cts_ctl_fsm
    import conv_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_en,
    input  logic cfg_chg,
    output logic edge_ok
);
    ctl_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CS_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CS_OFF:   nxt = trig_en ? CS_RUN : CS_OFF;
            CS_RUN:   nxt = !trig_en ? CS_OFF : (cfg_chg ? CS_PRIME : CS_RUN);
            CS_PRIME: nxt = !trig_en ? CS_OFF : (cfg_chg ? CS_PRIME : CS_RUN);
            default:  nxt = CS_OFF;
        endcase
    end

    // edges count only in settled operation with an unchanged configuration
    always_comb begin
        edge_ok = 1'b0;
        unique case (state)
            CS_RUN:   edge_ok = trig_en && !cfg_chg;
            CS_OFF,
            CS_PRIME: edge_ok = 1'b0;
            default:  edge_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/cts_sw_fsm.sv
`timescale 1ns/1ps
module cts_sw_fsm
    import conv_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    output logic armed,
    output logic rd_val
);
    sw_state_e state, nxt;
    logic      set_req;

    assign set_req = wr && wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_IDLE;
        else        state <= nxt;
    end

    // the bit clears itself after one cycle unless written again
    always_comb begin
        nxt = state;
        unique case (state)
            SW_IDLE:  nxt = set_req ? SW_ARMED : SW_IDLE;
            SW_ARMED: nxt = set_req ? SW_ARMED : SW_IDLE;
            default:  nxt = SW_IDLE;
        endcase
    end

    always_comb begin
        armed  = (state == SW_ARMED);
        rd_val = 1'b0;
    end
endmodule

// File: rtl/cts_pin_qual.sv
`timescale 1ns/1ps
module cts_pin_qual
    import conv_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       edge_ok,
    input  logic       busy,
    input  logic [1:0] mode,
    input  logic       s,
    output logic       hit
);
    logic hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist <= 1'b0;
        else if (clr) hist <= 1'b0;
        else          hist <= s;
    end

    always_comb begin
        hit = 1'b0;
        unique case (pmode_e'(mode))
            PM_LOW:  hit = !s && !busy;
            PM_HIGH: hit =  s && !busy;
            PM_FALL: hit = edge_ok &&  hist && !s;
            PM_RISE: hit = edge_ok && !hist &&  s;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/conv_trig_sel.sv
`timescale 1ns/1ps
module conv_trig_sel
    import conv_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int N_TMR       = 4,
    parameter int N_PWM       = 2,
    parameter int SEL_W       = 3,
    parameter int MODE_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_en,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [MODE_W-1:0] pin_mode,
    input  logic             sw_wr,
    input  logic             sw_wdata,
    input  logic             pin_raw,
    input  logic [N_TMR-1:0] evt_tmr,
    input  logic [N_PWM-1:0] evt_pwm,
    input  logic             busy,
    output logic             start,
    output logic             sw_bit_rd
);
    localparam int N_SRC  = 2 + N_TMR + N_PWM;
    localparam int N_SLOT = 1 << SEL_W;
    localparam int CFG_W  = SEL_W + MODE_W;

    logic              pin_s;
    logic              pin_hit;
    logic              sw_armed;
    logic              edge_ok;
    logic              cfg_chg;
    logic [CFG_W-1:0]  cfg_q;
    logic [N_SRC-1:0]  src_vec;
    logic [N_SLOT-1:0] slot;
    logic              fire;

    cts_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_s)
    );

    cts_sw_fsm u_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (sw_wr),
        .wdata  (sw_wdata),
        .armed  (sw_armed),
        .rd_val (sw_bit_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= {src_sel, pin_mode};
    end

    assign cfg_chg = trig_en && ({src_sel, pin_mode} != cfg_q);

    cts_ctl_fsm u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_en (trig_en),
        .cfg_chg (cfg_chg),
        .edge_ok (edge_ok)
    );

    cts_pin_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!trig_en),
        .edge_ok (edge_ok),
        .busy    (busy),
        .mode    (pin_mode[1:0]),
        .s       (pin_s),
        .hit     (pin_hit)
    );

    // slot order follows the select encoding: soft, pin, timers, pwms
    assign src_vec = {evt_pwm, evt_tmr, pin_hit, sw_armed};

    generate
        if (N_SLOT > N_SRC) begin : g_pad
            assign slot = {{(N_SLOT-N_SRC){1'b0}}, src_vec};
        end else begin : g_exact
            assign slot = src_vec[N_SLOT-1:0];
        end
    endgenerate

    assign fire = trig_en && slot[src_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start <= 1'b0;
        else        start <= fire;
    end
endmodule

// File: rtl/cts_checker.sv
`timescale 1ns/1ps
module cts_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_en,
    input logic [2:0] src_sel,
    input logic [1:0] pin_mode,
    input logic       sw_wr,
    input logic       sw_wdata,
    input logic [3:0] evt_tmr,
    input logic [1:0] evt_pwm,
    input logic       busy,
    input logic       sync_q,
    input logic       start
);
    logic [5:0] evt_bus;
    logic [2:0] evt_idx;
    logic       sel_evt;

    always_comb begin
        evt_bus = {evt_pwm, evt_tmr};
        evt_idx = src_sel - 3'd2;
        sel_evt = (src_sel >= 3'd2) && evt_bus[evt_idx];
    end

    // R2
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(trig_en));

    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> !start);

    // R4
    evt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && sel_evt) |=> start);

    // R3
    sw_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_wdata && trig_en && src_sel == 3'd0) ##1
        (trig_en && src_sel == 3'd0) |=> start);

    // R6
    level_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && src_sel == 3'd1 && pin_mode == 2'd1 && !busy && sync_q) |=> start);

    // R7
    busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd1 && !pin_mode[1] && busy) |=> !start);

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && src_sel == 3'd1 && pin_mode == 2'd3) |=> !start);

    // R8
    chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && src_sel == 3'd1 && pin_mode[1] &&
         ({src_sel, pin_mode} != $past({src_sel, pin_mode}))) |=> !start);
endmodule

bind conv_trig_sel cts_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_en  (trig_en),
    .src_sel  (src_sel),
    .pin_mode (pin_mode),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .evt_tmr  (evt_tmr),
    .evt_pwm  (evt_pwm),
    .busy     (busy),
    .sync_q   (pin_s),
    .start    (start)
);

// File: tb/sim_conv_trig_sel.sv
`timescale 1ns/1ps
module sim_conv_trig_sel;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       trig_en;
    logic [2:0] src_sel;
    logic [1:0] pin_mode;
    logic       sw_wr;
    logic       sw_wdata;
    logic       pin_raw;
    logic [3:0] evt_tmr;
    logic [1:0] evt_pwm;
    logic       busy;
    logic       start;
    logic       sw_bit_rd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    conv_trig_sel u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_en   (trig_en),
        .src_sel   (src_sel),
        .pin_mode  (pin_mode),
        .sw_wr     (sw_wr),
        .sw_wdata  (sw_wdata),
        .pin_raw   (pin_raw),
        .evt_tmr   (evt_tmr),
        .evt_pwm   (evt_pwm),
        .busy      (busy),
        .start     (start),
        .sw_bit_rd (sw_bit_rd)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // applies one stimulus kind and counts starts; pulse inputs drop after one cycle
    task automatic stim_count(input int kind, output int c);
        c = 0;
        case (kind)
            0: begin sw_wr = 1'b1; sw_wdata = 1'b1; end
            1: pin_raw = 1'b1;
            2, 3, 4, 5: evt_tmr[kind-2] = 1'b1;
            default: evt_pwm[kind-6] = 1'b1;
        endcase
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (start) c++;
            if (i == 0) begin
                sw_wr = 1'b0; sw_wdata = 1'b0; evt_tmr = '0; evt_pwm = '0;
            end
        end
        pin_raw = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (start) c++;
        end
    endtask

    initial begin
        int c;
        rst_n = 1'b0; trig_en = 1'b0; src_sel = '0; pin_mode = 2'd3;
        sw_wr = 1'b0; sw_wdata = 1'b0; pin_raw = 1'b0;
        evt_tmr = '0; evt_pwm = '0; busy = 1'b0;
        idle(3);
        chk("R9 start in reset", int'(start), 0);
        chk("R3 read value in reset", int'(sw_bit_rd), 0);
        rst_n = 1'b1;
        idle(2);
        chk("R9 start after reset", int'(start), 0);

        // R1 R2 sweep: every select against every stimulus, enabled and not
        for (int en = 0; en < 2; en++) begin
            for (int sel = 0; sel < 8; sel++) begin
                for (int st = 0; st < 8; st++) begin
                    trig_en = en[0]; src_sel = sel[2:0]; pin_mode = 2'd3;
                    idle(4);
                    stim_count(st, c);
                    chk($sformatf("R1 sweep en=%0d sel=%0d stim=%0d", en, sel, st),
                        c, (en == 1 && sel == st) ? 1 : 0);
                end
            end
        end

        // R3 exact timing and read-as-zero
        trig_en = 1'b1; src_sel = 3'd0; idle(4);
        sw_wr = 1'b1; sw_wdata = 1'b1;
        #0.1;
        chk("R3 read during write", int'(sw_bit_rd), 0);
        @(negedge clk); sw_wr = 1'b0; sw_wdata = 1'b0;
        chk("R3 start one edge after write", int'(start), 0);
        chk("R3 read after write", int'(sw_bit_rd), 0);
        @(negedge clk);
        chk("R3 start two edges after write", int'(start), 1);
        @(negedge clk);
        chk("R3 single pulse", int'(start), 0);
        sw_wr = 1'b1; sw_wdata = 1'b0;
        c = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); sw_wr = 1'b0;
            if (start) c++;
        end
        chk("R3 write of zero", c, 0);

        // R4 event latency
        src_sel = 3'd4; idle(4);
        evt_tmr[2] = 1'b1;
        @(negedge clk); evt_tmr = '0;
        chk("R4 timer2 start next edge", int'(start), 1);
        @(negedge clk);
        chk("R4 timer2 single pulse", int'(start), 0);
        src_sel = 3'd7; idle(4);
        evt_pwm[1] = 1'b1;
        @(negedge clk); evt_pwm = '0;
        chk("R4 pwm1 start next edge", int'(start), 1);

        // R5 synchronizer latency in rising mode
        src_sel = 3'd1; pin_mode = 2'd3; idle(6);
        pin_raw = 1'b1;
        @(negedge clk); chk("R5 edge 1", int'(start), 0);
        @(negedge clk); chk("R5 edge 2", int'(start), 0);
        @(negedge clk); chk("R5 edge 3", int'(start), 1);
        @(negedge clk); chk("R5 after", int'(start), 0);
        pin_raw = 1'b0; idle(6);

        // R6 R7 mode sweep: pin high for four cycles inside a 20-cycle window
        for (int b = 0; b < 2; b++) begin
            for (int m = 0; m < 4; m++) begin
                int exp;
                busy = b[0]; pin_mode = m[1:0]; pin_raw = 1'b0;
                idle(6);
                c = 0;
                for (int i = 0; i < 20; i++) begin
                    pin_raw = (i >= 5 && i < 9);
                    @(negedge clk);
                    if (start) c++;
                end
                pin_raw = 1'b0;
                if (m >= 2)      exp = 1;
                else if (b == 1) exp = 0;
                else if (m == 0) exp = 16;
                else             exp = 4;
                chk($sformatf("%s mode=%0d busy=%0d", (b == 1) ? "R7" : "R6", m, b), c, exp);
            end
        end
        busy = 1'b0; idle(4);

        // R2 enabling with pin already high in rising mode
        trig_en = 1'b0; src_sel = 3'd1; pin_mode = 2'd3; pin_raw = 1'b1;
        idle(6);
        trig_en = 1'b1;
        c = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (start) c++; end
        chk("R2 no start on enable", c, 0);
        pin_raw = 1'b0; idle(6);

        // R8 edge lands in the cycle the mode changes
        pin_mode = 2'd2; idle(6);
        pin_raw = 1'b1;
        idle(2);
        pin_mode = 2'd3;
        c = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (start) c++; end
        chk("R8 edge during mode change", c, 0);

        // R8 source switch with pin steady high
        src_sel = 3'd2; idle(4);
        src_sel = 3'd1;
        c = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (start) c++; end
        chk("R8 source switch steady pin", c, 0);
        pin_raw = 1'b0; idle(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule